// File: doc/BRIEF.md
# Key-Armed Flash Command Front-End

This block puts a small register map in front of an embedded flash array. Software fills a word write buffer, describes the transaction (word offset, bank select, size) in a transaction register, writes an arm key, then writes a 32-bit opcode into one of two command registers. The front-end starts an operation only if it is armed, idle, and the opcode is one of three known values. Progress is visible only through registers that clear themselves. The arm register drops to zero when the operation starts. The command register holds the opcode while the operation runs and drops to zero when it ends. The error register empties when it is read.

The flash cells are modelled by a main array split into a lower and an upper half, and by a small info bank. Program, erase and read each take a fixed, parameterised number of clock cycles. Program can only clear bits. Erase restores a whole aligned block to ones. Read fetches one info-bank word into a result register. The main array can also be read directly through a window in the address space.

Top module: `flash_cmd_fe`

## Requirements
- R1: After reset, the arm, both command, error and result registers read 0, and every main-array word reads 0xFFFFFFFF.
- R2: Writing 0xB11924E1 to the arm register (word address 0x00) makes it read 1. Any other value written there changes nothing. The arm register reads 0 once a command has started or has been rejected.
- R3: The command codes are erase 0x31415927, program 0x27182818 and read 0x16021765. Writing any other value to a command register has no effect. Writing a valid code while unarmed and idle also has no effect: no start, no error, and the arm state is kept.
- R4: An accepted opcode is readable in its command register from the cycle after the write. It stays there for exactly PROG_CYC, ERASE_CYC or READ_CYC cycles, then reads 0. At most one command register is nonzero at a time.
- R5: The lower command register (0x01) serves main words [0, MAIN_WORDS/2). The upper one (0x02) serves main words [MAIN_WORDS/2, MAIN_WORDS) and the info bank. A command is refused with error bit 2 and the arm is consumed if any of these holds: the offset lies outside the register's region; a program runs past the region's end; or a program has size >= BUF_WORDS.
- R6: The transaction register (0x03) holds the absolute word offset in bits [11:0], the info-bank select in bit 12 (1 = info), and a zero-based program size in bits [19:16] (0 means one word).
- R7: Program ANDs buffer word j into array word offset+j, for j = 0..size. Buffer word j sits at address 0x08+j and holds byte n of the little-endian data in bits [8n+7:8n].
- R8: Erase sets every word of the BLOCK_WORDS-aligned main block that contains the offset to 0xFFFFFFFF.
- R9: Erase with the info bit set, and read with the info bit clear, are refused with error bit 1. The arm is consumed and no cell changes.
- R10: Read copies the info-bank word at the offset into the result register (0x05) when it completes.
- R11: Writing a valid opcode while an operation runs sets error bit 0. The running operation and its command register readback are unaffected.
- R12: The error register (0x04) returns its bits on a read and clears at that read's clock edge. An error raised in the same cycle survives.
- R13: Main-array word w reads at address 0x80+w.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| re_i | input | 1 | Register read strobe (drives read side effects) |
| addr_i | input | 8 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |

## Verification
The bench builds the block with its defaults:
- a 64-word main array, so each half holds 32 words;
- an 8-word info bank;
- a 4-word write buffer;
- 8-word erase blocks;
- latencies of 6, 10 and 3 cycles.

An array this small lets the bench sweep every main word and check every info word after the random phase. Random offsets regularly land on the half boundary, on the last words of each region and just past the info bank. The short latencies make it cheap to count each operation's busy window exactly. They also make it cheap to collide a second command with a running one.

// File: rtl/flash_fe_pkg.sv
package flash_fe_pkg;
  localparam logic [31:0] ARM_KEY   = 32'hB11924E1;
  localparam logic [31:0] OPC_ERASE = 32'h31415927;
  localparam logic [31:0] OPC_PROG  = 32'h27182818;
  localparam logic [31:0] OPC_READ  = 32'h16021765;

  localparam int A_ARM    = 0;
  localparam int A_CMD_LO = 1;
  localparam int A_CMD_HI = 2;
  localparam int A_TRANS  = 3;
  localparam int A_ERR    = 4;
  localparam int A_RES    = 5;
  localparam int A_BUF    = 8;

  localparam int ERR_BUSY  = 0;
  localparam int ERR_BANK  = 1;
  localparam int ERR_RANGE = 2;

  typedef enum logic [1:0] {OP_NONE, OP_ERASE, OP_PROG, OP_READ} op_e;

  typedef struct packed {
    logic [3:0]  size;
    logic        info;
    logic [11:0] off;
  } trans_t;
endpackage

// File: rtl/flash_fe_decode.sv
module flash_fe_decode
  import flash_fe_pkg::*;
#(
  parameter int MAIN_WORDS = 64,
  parameter int INFO_WORDS = 8,
  parameter int BUF_WORDS  = 4
) (
  input  logic        wr_i,
  input  logic [31:0] opcode_i,
  input  logic        hi_i,
  input  trans_t      tr_i,
  input  logic        armed_i,
  input  logic        busy_i,
  output logic        start_o,
  output logic        reject_o,
  output op_e         op_o,
  output logic [2:0]  err_o
);
  localparam logic [12:0] HALF_L = 13'(MAIN_WORDS / 2);
  localparam logic [12:0] MAIN_L = 13'(MAIN_WORDS);
  localparam logic [12:0] INFO_L = 13'(INFO_WORDS);
  localparam logic [4:0]  BUF_L  = 5'(BUF_WORDS);

  logic [12:0] first, last;
  logic        bank_bad, range_ok;

  always_comb begin
    case (opcode_i)
      OPC_ERASE: op_o = OP_ERASE;
      OPC_PROG:  op_o = OP_PROG;
      OPC_READ:  op_o = OP_READ;
      default:   op_o = OP_NONE;
    endcase
    first    = {1'b0, tr_i.off};
    last     = (op_o == OP_PROG) ? first + {9'b0, tr_i.size} : first;
    bank_bad = (op_o == OP_ERASE && tr_i.info) || (op_o == OP_READ && !tr_i.info);
    if (tr_i.info)  range_ok = hi_i && (last < INFO_L);
    else if (hi_i)  range_ok = (first >= HALF_L) && (last < MAIN_L);
    else            range_ok = last < HALF_L;
    if (op_o == OP_PROG && {1'b0, tr_i.size} >= BUF_L) range_ok = 1'b0;

    start_o  = 1'b0;
    reject_o = 1'b0;
    err_o    = '0;
    if (wr_i && op_o != OP_NONE) begin
      if (busy_i) err_o[ERR_BUSY] = 1'b1;
      else if (armed_i) begin
        if (bank_bad) begin
          reject_o = 1'b1;
          err_o[ERR_BANK] = 1'b1;
        end else if (!range_ok) begin
          reject_o = 1'b1;
          err_o[ERR_RANGE] = 1'b1;
        end else begin
          start_o = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/flash_fe_seq.sv
module flash_fe_seq
  import flash_fe_pkg::*;
#(
  parameter int PROG_CYC  = 6,
  parameter int ERASE_CYC = 10,
  parameter int READ_CYC  = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  op_e  op_i,
  output logic busy_o,
  output logic done_o,
  output op_e  op_o
);
  localparam int MAX_A   = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int MAX_CYC = (MAX_A > READ_CYC) ? MAX_A : READ_CYC;
  localparam int CW      = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

  logic [CW-1:0] cnt_q, lat_m1;
  logic          busy_q;
  op_e           op_q;

  always_comb begin
    case (op_i)
      OP_PROG:  lat_m1 = CW'(PROG_CYC - 1);
      OP_ERASE: lat_m1 = CW'(ERASE_CYC - 1);
      default:  lat_m1 = CW'(READ_CYC - 1);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      op_q   <= OP_NONE;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= lat_m1;
      op_q   <= op_i;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_q <= 1'b0;
        op_q   <= OP_NONE;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);
  assign op_o   = op_q;
endmodule

// File: rtl/flash_fe_array.sv
module flash_fe_array
  import flash_fe_pkg::*;
#(
  parameter int MAIN_WORDS  = 64,
  parameter int INFO_WORDS  = 8,
  parameter int BUF_WORDS   = 4,
  parameter int BLOCK_WORDS = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      done_i,
  input  op_e                       op_i,
  input  trans_t                    tr_i,
  input  logic [BUF_WORDS-1:0][31:0] buf_i,
  input  logic [$clog2(MAIN_WORDS)-1:0] rd_idx_i,
  output logic [31:0]               rd_word_o,
  output logic [31:0]               info_word_o
);
  localparam int BIW    = $clog2(BUF_WORDS);
  localparam int IW     = $clog2(INFO_WORDS);
  localparam int BLK_SH = $clog2(BLOCK_WORDS);

  logic [MAIN_WORDS-1:0][31:0] main_q, main_d;
  logic [INFO_WORDS-1:0][31:0] info_q, info_d;
  logic [12:0] off_x;

  assign off_x = {1'b0, tr_i.off};

  for (genvar w = 0; w < MAIN_WORDS; w++) begin : g_main
    localparam logic [12:0] WL = 13'(w);
    logic [12:0] diff;
    logic        hit_p, hit_e;
    assign diff  = WL - off_x;
    assign hit_p = (op_i == OP_PROG) && !tr_i.info && (WL >= off_x) && (diff <= {9'b0, tr_i.size});
    assign hit_e = (op_i == OP_ERASE) && !tr_i.info && ((WL >> BLK_SH) == (off_x >> BLK_SH));
    assign main_d[w] = hit_e ? '1 : hit_p ? (main_q[w] & buf_i[diff[BIW-1:0]]) : main_q[w];
  end

  for (genvar w = 0; w < INFO_WORDS; w++) begin : g_info
    localparam logic [12:0] WL = 13'(w);
    logic [12:0] diff;
    logic        hit_p;
    assign diff  = WL - off_x;
    assign hit_p = (op_i == OP_PROG) && tr_i.info && (WL >= off_x) && (diff <= {9'b0, tr_i.size});
    assign info_d[w] = hit_p ? (info_q[w] & buf_i[diff[BIW-1:0]]) : info_q[w];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      main_q <= '1;
      info_q <= '1;
    end else if (done_i) begin
      main_q <= main_d;
      info_q <= info_d;
    end
  end

  assign rd_word_o   = main_q[rd_idx_i];
  assign info_word_o = info_q[tr_i.off[IW-1:0]];
endmodule

// File: rtl/flash_cmd_fe.sv
module flash_cmd_fe
  import flash_fe_pkg::*;
#(
  parameter int MAIN_WORDS  = 64,
  parameter int INFO_WORDS  = 8,
  parameter int BUF_WORDS   = 4,
  parameter int BLOCK_WORDS = 8,
  parameter int PROG_CYC    = 6,
  parameter int ERASE_CYC   = 10,
  parameter int READ_CYC    = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic        re_i,
  input  logic [7:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o
);
  localparam int AW  = 8;
  localparam int MW  = $clog2(MAIN_WORDS);
  localparam int BIW = $clog2(BUF_WORDS);

  logic                       armed_q;
  logic [31:0]                cmd_lo_q, cmd_hi_q, res_q;
  logic [2:0]                 err_q, err_set;
  trans_t                     tr_q, act_q;
  logic [BUF_WORDS-1:0][31:0] buf_q;

  logic wr_cmd, cmd_hi_sel, rd_err, wr_buf;
  logic start, reject, busy, done;
  op_e  dec_op, cur_op;
  logic [31:0] arr_word, info_word;

  assign cmd_hi_sel = addr_i == AW'(A_CMD_HI);
  assign wr_cmd     = we_i && (addr_i == AW'(A_CMD_LO) || cmd_hi_sel);
  assign rd_err     = re_i && addr_i == AW'(A_ERR);
  assign wr_buf     = we_i && addr_i >= AW'(A_BUF) && addr_i < AW'(A_BUF + BUF_WORDS);

  flash_fe_decode #(
    .MAIN_WORDS(MAIN_WORDS), .INFO_WORDS(INFO_WORDS), .BUF_WORDS(BUF_WORDS)
  ) u_dec (
    .wr_i(wr_cmd), .opcode_i(wdata_i), .hi_i(cmd_hi_sel), .tr_i(tr_q),
    .armed_i(armed_q), .busy_i(busy),
    .start_o(start), .reject_o(reject), .op_o(dec_op), .err_o(err_set)
  );

  flash_fe_seq #(
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .READ_CYC(READ_CYC)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .op_i(dec_op),
    .busy_o(busy), .done_o(done), .op_o(cur_op)
  );

  flash_fe_array #(
    .MAIN_WORDS(MAIN_WORDS), .INFO_WORDS(INFO_WORDS),
    .BUF_WORDS(BUF_WORDS), .BLOCK_WORDS(BLOCK_WORDS)
  ) u_arr (
    .clk_i(clk_i), .rst_ni(rst_ni), .done_i(done), .op_i(cur_op), .tr_i(act_q),
    .buf_i(buf_q), .rd_idx_i(addr_i[MW-1:0]),
    .rd_word_o(arr_word), .info_word_o(info_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q  <= 1'b0;
      cmd_lo_q <= '0;
      cmd_hi_q <= '0;
      res_q    <= '0;
      err_q    <= '0;
      tr_q     <= '0;
      act_q    <= '0;
      buf_q    <= '0;
    end else begin
      if (we_i && addr_i == AW'(A_ARM) && wdata_i == ARM_KEY) armed_q <= 1'b1;
      if (start || reject) armed_q <= 1'b0;
      if (start) begin
        if (cmd_hi_sel) cmd_hi_q <= wdata_i;
        else            cmd_lo_q <= wdata_i;
        act_q <= tr_q;  // parameters frozen for the whole operation
      end
      if (done) begin
        cmd_lo_q <= '0;
        cmd_hi_q <= '0;
        if (cur_op == OP_READ) res_q <= info_word;
      end
      if (we_i && addr_i == AW'(A_TRANS))
        tr_q <= '{size: wdata_i[19:16], info: wdata_i[12], off: wdata_i[11:0]};
      if (wr_buf) buf_q[addr_i[BIW-1:0]] <= wdata_i;
      err_q <= (rd_err ? 3'b0 : err_q) | err_set;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i[AW-1]) begin
      if (addr_i[AW-2:0] < 7'(MAIN_WORDS)) rdata_o = arr_word;
    end else if (addr_i >= AW'(A_BUF) && addr_i < AW'(A_BUF + BUF_WORDS)) begin
      rdata_o = buf_q[addr_i[BIW-1:0]];
    end else begin
      case (addr_i)
        AW'(A_ARM):    rdata_o = {31'b0, armed_q};
        AW'(A_CMD_LO): rdata_o = cmd_lo_q;
        AW'(A_CMD_HI): rdata_o = cmd_hi_q;
        AW'(A_TRANS):  rdata_o = {12'b0, tr_q.size, 3'b0, tr_q.info, tr_q.off};
        AW'(A_ERR):    rdata_o = {29'b0, err_q};
        AW'(A_RES):    rdata_o = res_q;
        default:       rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/flash_fe_chk.sv
module flash_fe_chk
  import flash_fe_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        we_i,
  input logic        re_i,
  input logic [7:0]  addr_i,
  input logic [31:0] wdata_i,
  input logic        busy_i,
  input logic        armed_i,
  input logic [31:0] cmd_lo_i,
  input logic [31:0] cmd_hi_i,
  input logic [2:0]  err_i,
  input logic [2:0]  err_set_i
);
  logic valid_opc, cmd_wr;
  assign valid_opc = wdata_i == OPC_ERASE || wdata_i == OPC_PROG || wdata_i == OPC_READ;
  assign cmd_wr    = we_i && (addr_i == 8'(A_CMD_LO) || addr_i == 8'(A_CMD_HI));

  // R4
  one_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_lo_i != '0 && cmd_hi_i != '0));
  // R4
  idle_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (cmd_lo_i == '0 && cmd_hi_i == '0));
  // R11
  cmd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> ($stable(cmd_lo_i) && $stable(cmd_hi_i)));
  // R2
  arm_used_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> !armed_i);
  // R12
  err_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i == 8'(A_ERR) && err_set_i == '0) |=> err_i == '0);
  // R11
  busy_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && cmd_wr && valid_opc) |=> err_i[ERR_BUSY]);
endmodule

bind flash_cmd_fe flash_fe_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .re_i(re_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .busy_i(busy), .armed_i(armed_q), .cmd_lo_i(cmd_lo_q),
  .cmd_hi_i(cmd_hi_q), .err_i(err_q), .err_set_i(err_set)
);

// File: tb/tb_flash_cmd_fe.sv
`timescale 1ns/1ps
module tb_flash_cmd_fe;
  localparam int MAIN = 64, HALF = 32, INFO = 8, BUFW = 4, BLK = 8;
  localparam int PC = 6, EC = 10, RC = 3;
  localparam logic [31:0] KEY = 32'hB11924E1;
  localparam logic [31:0] C_ER = 32'h31415927, C_PR = 32'h27182818, C_RD = 32'h16021765;

  logic clk = 0, rst_n = 0, we = 0, re = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  int checks = 0, fails = 0;
  logic [31:0] main_m [MAIN];
  logic [31:0] info_m [INFO];
  logic [31:0] buf_m  [BUFW];

  always #2.5 clk = ~clk;

  flash_cmd_fe dut (.clk_i(clk), .rst_ni(rst_n), .we_i(we), .re_i(re),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    we = 1; addr = 8'(a); wdata = d;
    @(negedge clk);
    we = 0;
  endtask

  task automatic rd(int a, output logic [31:0] v);
    re = 1; addr = 8'(a);
    #1 v = rdata;
    @(negedge clk);
    re = 0;
  endtask

  // R6: offset [11:0], info bit 12, zero-based size [19:16]
  function automatic logic [31:0] tr(int off, bit info, int size);
    return {12'b0, 4'(size), 3'b0, info, 12'(off)};
  endfunction

  function automatic logic [31:0] opc(int op);
    return (op == 0) ? C_ER : (op == 1) ? C_PR : C_RD;
  endfunction

  function automatic int lat(int op);
    return (op == 0) ? EC : (op == 1) ? PC : RC;
  endfunction

  // R5 R9: expected error code of a command issued while armed and idle
  function automatic logic [2:0] exp_err(int op, bit hi, bit info, int off, int size);
    int last;
    bit ok;
    if ((op == 0 && info) || (op == 2 && !info)) return 3'b010;
    if (op == 1 && size >= BUFW) return 3'b100;
    last = (op == 1) ? off + size : off;
    if (info) ok = hi && last < INFO;
    else if (hi) ok = off >= HALF && last < MAIN;
    else ok = last < HALF;
    return ok ? 3'b000 : 3'b100;
  endfunction

  task automatic set_buf(int j, logic [31:0] d);
    wr(8 + j, d);
    buf_m[j] = d;
  endtask

  task automatic do_op(int op, bit hi, bit info, int off, int size, string req);
    logic [2:0] e;
    logic [31:0] v;
    int n;
    e = exp_err(op, hi, info, off, size);
    wr(3, tr(off, info, size));
    wr(0, KEY);
    wr(hi ? 2 : 1, opc(op));
    n = 0;
    rd(hi ? 2 : 1, v);
    while (v != 0 && n < 200) begin
      n++;
      rd(hi ? 2 : 1, v);
    end
    chk({req, " busy window (R4)"}, n, (e == 0) ? lat(op) : 0);
    rd(4, v);
    chk({req, " error code"}, v, {29'b0, e});
    if (e == 0) begin
      if (op == 0) begin
        for (int w = (off / BLK) * BLK; w < (off / BLK) * BLK + BLK; w++) main_m[w] = '1;
      end else if (op == 1) begin
        for (int j = 0; j <= size; j++)
          if (info) info_m[off + j] &= buf_m[j];
          else main_m[off + j] &= buf_m[j];
      end else begin
        rd(5, v);
        chk({req, " read result (R10)"}, v, info_m[off]);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    for (int w = 0; w < MAIN; w++) main_m[w] = '1;
    for (int w = 0; w < INFO; w++) info_m[w] = '1;
    for (int j = 0; j < BUFW; j++) buf_m[j] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd(0, v); chk("R1 arm", v, 0);
    rd(1, v); chk("R1 cmd lo", v, 0);
    rd(2, v); chk("R1 cmd hi", v, 0);
    rd(4, v); chk("R1 err", v, 0);
    rd(5, v); chk("R1 result", v, 0);
    rd(8'h80, v); chk("R1 word 0", v, 32'hFFFFFFFF);
    rd(8'h80 + MAIN - 1, v); chk("R1 last word", v, 32'hFFFFFFFF);

    // R2 wrong key ignored
    wr(0, 32'h12345678); rd(0, v); chk("R2 wrong key", v, 0);

    // R3 unarmed program ignored
    set_buf(0, 32'h0);
    wr(3, tr(0, 0, 0));
    wr(1, C_PR);
    rd(1, v); chk("R3 unarmed no start", v, 0);
    rd(4, v); chk("R3 unarmed no error", v, 0);
    rd(8'h80, v); chk("R3 unarmed cell kept", v, 32'hFFFFFFFF);

    // R3 invalid opcode keeps arm
    wr(0, KEY); rd(0, v); chk("R2 armed", v, 1);
    wr(1, 32'hDEADBEEF);
    rd(1, v); chk("R3 bad opcode no start", v, 0);
    rd(0, v); chk("R3 arm kept", v, 1);

    // R7 little-endian program, lower half
    set_buf(0, 32'h44332211); set_buf(1, 32'hF0F0FFFF);
    do_op(1, 0, 0, 3, 1, "R7 program lo");
    rd(8'h80 + 3, v); chk("R7 byte order", v, 32'h44332211);
    rd(8'h80 + 4, v); chk("R7 second word", v, 32'hF0F0FFFF);
    set_buf(0, 32'hFF00FF00);
    do_op(1, 0, 0, 3, 0, "R7 program AND");
    rd(8'h80 + 3, v); chk("R7 only clears bits", v, 32'h44002200);

    // R5 boundaries
    do_op(1, 0, 0, HALF - 2, 3, "R5 past lower end");
    do_op(1, 1, 0, HALF - 1, 0, "R5 hi below half");
    do_op(1, 0, 0, HALF, 0, "R5 lo at half");
    do_op(1, 1, 0, HALF, BUFW - 1, "R5 hi at half");
    do_op(1, 1, 0, MAIN - 1, 1, "R5 past upper end");
    do_op(1, 0, 0, 0, BUFW, "R5 size too large");

    // R8 erase block
    do_op(0, 0, 0, 5, 0, "R8 erase lo");
    rd(8'h80 + 3, v); chk("R8 block erased", v, 32'hFFFFFFFF);

    // R9 bank rejections consume the arm
    do_op(0, 1, 1, 0, 0, "R9 erase info");
    rd(0, v); chk("R9 arm consumed", v, 0);
    do_op(2, 1, 0, 40, 0, "R9 read main");

    // R10 info program and read
    set_buf(0, 32'hA5A5A5A5); set_buf(1, 32'h0F0F0F0F);
    do_op(1, 1, 1, 2, 1, "R10 program info");
    do_op(2, 1, 1, 3, 0, "R10 read info");
    do_op(2, 0, 1, 3, 0, "R5 read info via lo");

    // R11 collision while busy, R2 arm drop, R12 read-clear
    wr(3, tr(8, 0, 0)); wr(0, KEY); wr(1, C_ER);
    rd(0, v); chk("R2 arm drops at start", v, 0);
    wr(2, C_PR);
    rd(1, v); chk("R11 running opcode kept", v, C_ER);
    rd(2, v); chk("R11 no second start", v, 0);
    repeat (EC) @(negedge clk);
    for (int w = 8; w < 16; w++) main_m[w] = '1;
    rd(4, v); chk("R11 busy error", v, 3'b001);
    rd(4, v); chk("R12 cleared by read", v, 0);

    // random mix
    for (int it = 0; it < 40; it++) begin
      int op, off, size;
      bit info, hi;
      op   = $urandom % 3;
      info = ($urandom % 4) == 0;
      hi   = info ? (($urandom % 4) != 0) : bit'($urandom % 2);
      off  = info ? $urandom % 10 : $urandom % MAIN;
      size = $urandom % 5;
      for (int j = 0; j < BUFW; j++) set_buf(j, $urandom | $urandom);
      do_op(op, hi, info, off, size, "random");
    end

    // R13 full sweep of the main array
    for (int w = 0; w < MAIN; w++) begin
      rd(8'h80 + w, v); chk("R13 sweep", v, main_m[w]);
    end
    for (int w = 0; w < INFO; w++) do_op(2, 1, 1, w, 0, "R10 info sweep");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule